// File: doc/BRIEF.md
# Two-Clock Byte-Lane Static RAM

This block is a word-organised memory with two fully independent access ports. Each port has its own clock and reset, and each can read or write any word at any time. A port is selected by a pair of enables of opposite polarity, so memory banks can be stacked without decode logic. Each access is split into an upper and a lower byte lane, and the two lanes are masked separately on writes and on reads.

On each port, a static mode input sets when read data arrives. In flow-through mode it appears right after the clock edge that captures the address. In pipelined mode it appears one edge later. Tri-state pins are modelled as a data bus plus one valid flag per lane: a lane that would float reads as valid 0 with data 0.

An asynchronous output enable blanks both lanes at once. The drive state seen in any cycle is set by the controls captured at the edge before it.

Top module: `dpram_bytelane`

## Requirements
- R1: A port is selected at an edge only when its `en0_n` is 0 and its `en1` is 1. An unselected edge writes nothing. After that edge, both lane-valid flags of the port are 0.
- R2: A selected write (`rd`=0) stores only the lanes whose select is 0: `hi_n` guards bits 15..8 and `lo_n` guards bits 7..0. With both selects at 1, the word is left unchanged.
- R3: A selected read (`rd`=1) raises the valid flag only for lanes whose select was 0. Flag bit 1 is the upper lane and bit 0 is the lower lane. A lane whose flag is 0 shows data 0.
- R4: While `oe_n` is 1, both valid flags and all data bits are 0, with no clock needed. When `oe_n` returns to 0, the held result reappears.
- R5: With `pipe`=0, read data and flags appear after the same edge that captures the address.
- R6: With `pipe`=1, read data and flags appear one edge later than with `pipe`=0.
- R7: With `pipe`=1, after an edge where the port is unselected, the flags stay 0 until the port has been selected on two consecutive edges.
- R8: Both ports share one array. A word written through either port is read back through the other.
- R9: When one port writes and the other port reads the same word at the same edge, the read returns the old contents. Reads at later edges return the new contents.
- R10: While reset is held, and right after it is released, both flags of the port are 0 and its data is 0.
- R11: With `pipe`=0, the flags are 0 after any write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_clk | input | 1 | Port A clock |
| a_rst_n | input | 1 | Port A active-low reset |
| a_en0_n | input | 1 | Port A enable, active low |
| a_en1 | input | 1 | Port A enable, active high |
| a_rd | input | 1 | Port A 1 = read, 0 = write |
| a_hi_n | input | 1 | Port A upper lane select, active low |
| a_lo_n | input | 1 | Port A lower lane select, active low |
| a_oe_n | input | 1 | Port A asynchronous output enable, active low |
| a_pipe | input | 1 | Port A static mode, 1 = pipelined |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | 2*LANE_W | Port A write data |
| a_rdata | output | 2*LANE_W | Port A read data |
| a_rvalid | output | 2 | Port A per-lane drive flags |
| b_clk | input | 1 | Port B clock |
| b_rst_n | input | 1 | Port B active-low reset |
| b_en0_n | input | 1 | Port B enable, active low |
| b_en1 | input | 1 | Port B enable, active high |
| b_rd | input | 1 | Port B 1 = read, 0 = write |
| b_hi_n | input | 1 | Port B upper lane select, active low |
| b_lo_n | input | 1 | Port B lower lane select, active low |
| b_oe_n | input | 1 | Port B asynchronous output enable, active low |
| b_pipe | input | 1 | Port B static mode, 1 = pipelined |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | 2*LANE_W | Port B write data |
| b_rdata | output | 2*LANE_W | Port B read data |
| b_rvalid | output | 2 | Port B per-lane drive flags |

## Verification
The bench builds the block with its defaults: an 8-bit address (256 words) and 8-bit lanes. This keeps the whole array small, so every word the bench touches is first written with known data. Both ports share one clock so that a write on one port and a read on the other land on exactly the same edge, which brings the old-data collision rule within reach. Port A runs flow-through and port B runs pipelined, so both latencies and the pipelined reactivation rule are covered in one build.

// File: rtl/dpram_port.sv
module dpram_port #(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 8,
  parameter bit OWN_EQ = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en0_n,
  input  logic                en1,
  input  logic                rd,
  input  logic                hi_n,
  input  logic                lo_n,
  input  logic                oe_n,
  input  logic                pipe,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [2*LANE_W-1:0] wdata,
  output logic [2*LANE_W-1:0] rdata,
  output logic [1:0]          rvalid,
  input  logic [ADDR_W-1:0]   peer_addr,
  output logic [2*LANE_W-1:0] peer_word,
  output logic [1:0]          peer_tag,
  input  logic [2*LANE_W-1:0] far_word,
  input  logic [1:0]          far_tag
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int DW    = 2 * LANE_W;

  logic [DW-1:0] bank [DEPTH];
  logic [1:0]    tag  [DEPTH];

  logic          sel_in;
  logic [1:0]    lanes_in;
  logic [DW-1:0] live;
  logic          sel_q;
  logic [1:0]    en_q, en_p, drive;
  logic [DW-1:0] dq, dp, dsel;

  assign sel_in    = !en0_n && en1;
  assign lanes_in  = {!hi_n, !lo_n};
  assign peer_word = bank[peer_addr];
  assign peer_tag  = tag[peer_addr];

  always_comb begin
    for (int l = 0; l < 2; l++) begin
      if ((tag[addr][l] == far_tag[l]) == OWN_EQ)
        live[l*LANE_W +: LANE_W] = bank[addr][l*LANE_W +: LANE_W];
      else
        live[l*LANE_W +: LANE_W] = far_word[l*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk) begin
    for (int l = 0; l < 2; l++) begin
      if (sel_in && !rd && lanes_in[l]) begin
        bank[addr][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
        tag[addr][l] <= OWN_EQ ? far_tag[l] : !far_tag[l];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      en_q  <= '0;
      en_p  <= '0;
      dq    <= '0;
      dp    <= '0;
    end else begin
      sel_q <= sel_in;
      en_q  <= (sel_in && rd) ? lanes_in : 2'b00;
      en_p  <= en_q;
      dq    <= live;
      dp    <= dq;
    end
  end

  assign drive  = pipe ? (en_p & {2{sel_q}}) : en_q;
  assign rvalid = oe_n ? 2'b00 : drive;
  assign dsel   = pipe ? dp : dq;

  for (genvar l = 0; l < 2; l++) begin : g_lane
    assign rdata[l*LANE_W +: LANE_W] = rvalid[l] ? dsel[l*LANE_W +: LANE_W] : '0;
  end

  p_unselected_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_in && !oe_n && !pipe) |=> (rvalid == 2'b00));

  p_lane_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe && sel_in && rd && hi_n) |=> !rvalid[1]);

  p_oe_blanks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (rvalid == 2'b00));

  p_reactivate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe && !sel_in) |-> ##2 (rvalid == 2'b00));

  p_write_silent_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe && sel_in && !rd) |=> (rvalid == 2'b00));
endmodule

// File: rtl/dpram_bytelane.sv
module dpram_bytelane #(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 8
) (
  input  logic                a_clk,
  input  logic                a_rst_n,
  input  logic                a_en0_n,
  input  logic                a_en1,
  input  logic                a_rd,
  input  logic                a_hi_n,
  input  logic                a_lo_n,
  input  logic                a_oe_n,
  input  logic                a_pipe,
  input  logic [ADDR_W-1:0]   a_addr,
  input  logic [2*LANE_W-1:0] a_wdata,
  output logic [2*LANE_W-1:0] a_rdata,
  output logic [1:0]          a_rvalid,
  input  logic                b_clk,
  input  logic                b_rst_n,
  input  logic                b_en0_n,
  input  logic                b_en1,
  input  logic                b_rd,
  input  logic                b_hi_n,
  input  logic                b_lo_n,
  input  logic                b_oe_n,
  input  logic                b_pipe,
  input  logic [ADDR_W-1:0]   b_addr,
  input  logic [2*LANE_W-1:0] b_wdata,
  output logic [2*LANE_W-1:0] b_rdata,
  output logic [1:0]          b_rvalid
);
  logic [2*LANE_W-1:0] word_a2b, word_b2a;
  logic [1:0]          tag_a2b, tag_b2a;

  dpram_port #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .OWN_EQ(1'b1)) u_pa (
    .clk(a_clk), .rst_n(a_rst_n), .en0_n(a_en0_n), .en1(a_en1), .rd(a_rd),
    .hi_n(a_hi_n), .lo_n(a_lo_n), .oe_n(a_oe_n), .pipe(a_pipe),
    .addr(a_addr), .wdata(a_wdata), .rdata(a_rdata), .rvalid(a_rvalid),
    .peer_addr(b_addr), .peer_word(word_a2b), .peer_tag(tag_a2b),
    .far_word(word_b2a), .far_tag(tag_b2a)
  );

  dpram_port #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .OWN_EQ(1'b0)) u_pb (
    .clk(b_clk), .rst_n(b_rst_n), .en0_n(b_en0_n), .en1(b_en1), .rd(b_rd),
    .hi_n(b_hi_n), .lo_n(b_lo_n), .oe_n(b_oe_n), .pipe(b_pipe),
    .addr(b_addr), .wdata(b_wdata), .rdata(b_rdata), .rvalid(b_rvalid),
    .peer_addr(a_addr), .peer_word(word_b2a), .peer_tag(tag_b2a),
    .far_word(word_a2b), .far_tag(tag_a2b)
  );
endmodule

// File: tb/dpram_bytelane_tb.sv
module dpram_bytelane_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n;
  logic a_en0_n, a_en1, a_rd, a_hi_n, a_lo_n, a_oe_n;
  logic b_en0_n, b_en1, b_rd, b_hi_n, b_lo_n, b_oe_n;
  logic [7:0]  a_addr, b_addr;
  logic [15:0] a_wdata, b_wdata, a_rdata, b_rdata;
  logic [1:0]  a_rvalid, b_rvalid;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  dpram_bytelane u_dut (
    .a_clk(clk), .a_rst_n(rst_n), .a_en0_n(a_en0_n), .a_en1(a_en1), .a_rd(a_rd),
    .a_hi_n(a_hi_n), .a_lo_n(a_lo_n), .a_oe_n(a_oe_n), .a_pipe(1'b0),
    .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata), .a_rvalid(a_rvalid),
    .b_clk(clk), .b_rst_n(rst_n), .b_en0_n(b_en0_n), .b_en1(b_en1), .b_rd(b_rd),
    .b_hi_n(b_hi_n), .b_lo_n(b_lo_n), .b_oe_n(b_oe_n), .b_pipe(1'b1),
    .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata), .b_rvalid(b_rvalid)
  );

  // {rd, hi_n, lo_n, addr, wdata, expected valid, expected data}
  localparam logic [44:0] VEC [11] = '{
    {1'b0, 1'b0, 1'b0, 8'h10, 16'h1234, 2'b00, 16'h0000},
    {1'b0, 1'b0, 1'b0, 8'h11, 16'h5678, 2'b00, 16'h0000},
    {1'b0, 1'b0, 1'b1, 8'h11, 16'hABCD, 2'b00, 16'h0000},
    {1'b0, 1'b1, 1'b0, 8'h10, 16'h99EF, 2'b00, 16'h0000},
    {1'b1, 1'b0, 1'b0, 8'h10, 16'h0000, 2'b11, 16'h12EF},
    {1'b1, 1'b0, 1'b0, 8'h11, 16'h0000, 2'b11, 16'hAB78},
    {1'b1, 1'b0, 1'b1, 8'h10, 16'h0000, 2'b10, 16'h1200},
    {1'b1, 1'b1, 1'b0, 8'h11, 16'h0000, 2'b01, 16'h0078},
    {1'b1, 1'b1, 1'b1, 8'h10, 16'h0000, 2'b00, 16'h0000},
    {1'b0, 1'b1, 1'b1, 8'h10, 16'hFFFF, 2'b00, 16'h0000},
    {1'b1, 1'b0, 1'b0, 8'h10, 16'h0000, 2'b11, 16'h12EF}
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [17:0] got, input logic [17:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got valid=%b data=%h, expected valid=%b data=%h",
               tag, got[17:16], got[15:0], exp[17:16], exp[15:0]);
    end
  endtask

  task automatic a_op(input logic sel, input logic rd, input logic hn, input logic ln,
                      input logic [7:0] ad, input logic [15:0] wd);
    a_en0_n = !sel; a_en1 = 1'b1; a_rd = rd; a_hi_n = hn; a_lo_n = ln;
    a_addr = ad; a_wdata = wd;
  endtask

  task automatic b_op(input logic sel, input logic rd, input logic [7:0] ad, input logic [15:0] wd);
    b_en0_n = !sel; b_en1 = 1'b1; b_rd = rd; b_hi_n = 1'b0; b_lo_n = 1'b0;
    b_addr = ad; b_wdata = wd;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    a_oe_n = 1'b0; b_oe_n = 1'b0;
    a_op(1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 16'h0000);
    b_op(1'b0, 1'b1, 8'h00, 16'h0000);
    tick(); tick();
    chk("R10 reset A", {a_rvalid, a_rdata}, 18'h0);
    chk("R10 reset B", {b_rvalid, b_rdata}, 18'h0);
    rst_n = 1'b1;
    tick();
    chk("R10 after release A", {a_rvalid, a_rdata}, 18'h0);

    // table: port A flow-through, R2 R3 R5 R11
    for (int i = 0; i < 11; i++) begin
      a_op(1'b1, VEC[i][44], VEC[i][43], VEC[i][42], VEC[i][41:34], VEC[i][33:18]);
      tick();
      chk($sformatf("R2/R3/R5/R11 vector %0d", i), {a_rvalid, a_rdata}, VEC[i][17:0]);
    end

    // R1: write with en0_n high ignored, read with en1 low silent
    a_en0_n = 1'b1; a_en1 = 1'b1; a_rd = 1'b0; a_hi_n = 1'b0; a_lo_n = 1'b0;
    a_addr = 8'h10; a_wdata = 16'h0000;
    tick();
    a_en0_n = 1'b0; a_en1 = 1'b0; a_rd = 1'b1;
    tick();
    chk("R1 unselected read silent", {a_rvalid, a_rdata}, 18'h0);
    a_op(1'b1, 1'b1, 1'b0, 1'b0, 8'h10, 16'h0);
    tick();
    chk("R1 unselected write ignored", {a_rvalid, a_rdata}, {2'b11, 16'h12EF});

    // R4: asynchronous output enable
    a_oe_n = 1'b1; #1;
    chk("R4 oe high blanks", {a_rvalid, a_rdata}, 18'h0);
    a_oe_n = 1'b0; #1;
    chk("R4 oe low restores", {a_rvalid, a_rdata}, {2'b11, 16'h12EF});
    a_op(1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 16'h0);

    // R6 R7 R8: port B pipelined reads of words written by A
    b_op(1'b1, 1'b1, 8'h10, 16'h0);
    tick();
    chk("R7 first selected edge silent", {b_rvalid, b_rdata}, 18'h0);
    b_op(1'b1, 1'b1, 8'h11, 16'h0);
    tick();
    chk("R6/R8 pipelined read 0x10", {b_rvalid, b_rdata}, {2'b11, 16'h12EF});
    b_op(1'b0, 1'b1, 8'h11, 16'h0);
    tick();
    chk("R7 deselect blanks", {b_rvalid, b_rdata}, 18'h0);
    b_op(1'b1, 1'b1, 8'h11, 16'h0);
    tick();
    chk("R7 one selected edge still silent", {b_rvalid, b_rdata}, 18'h0);
    tick();
    chk("R7 reactivated after two edges", {b_rvalid, b_rdata}, {2'b11, 16'hAB78});

    // R9: same-edge write (A) and read (B) of one word
    a_op(1'b1, 1'b0, 1'b0, 1'b0, 8'h20, 16'h1111);
    b_op(1'b1, 1'b1, 8'h10, 16'h0);
    tick();
    a_op(1'b1, 1'b0, 1'b0, 1'b0, 8'h20, 16'h2222);
    b_op(1'b1, 1'b1, 8'h20, 16'h0);
    tick();
    a_op(1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 16'h0);
    tick();
    chk("R9 same-edge read sees old", {b_rvalid, b_rdata}, {2'b11, 16'h1111});
    tick();
    chk("R9 later read sees new", {b_rvalid, b_rdata}, {2'b11, 16'h2222});

    // R8 reverse direction: B writes, A reads
    b_op(1'b1, 1'b0, 8'h30, 16'hCAFE);
    tick();
    b_op(1'b0, 1'b1, 8'h00, 16'h0);
    a_op(1'b1, 1'b1, 1'b0, 1'b0, 8'h30, 16'h0);
    tick();
    chk("R8 A reads word written by B", {a_rvalid, a_rdata}, {2'b11, 16'hCAFE});
    // R8: A overwrites lower lane of a B-written word, B reads merged
    a_op(1'b1, 1'b0, 1'b1, 1'b0, 8'h30, 16'h0055);
    tick();
    a_op(1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 16'h0);
    b_op(1'b1, 1'b1, 8'h30, 16'h0);
    tick(); tick();
    chk("R8 merged lanes across ports", {b_rvalid, b_rdata}, {2'b11, 16'hCA55});

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule